// File: doc/BRIEF.md
# Sparse-Corrected CIC Decimator

This block lowers the sample rate of a signed stream by a fixed factor. It runs a chain of integrators at the input rate. It keeps one result out of every `RATE` accepted samples, then runs an equal number of differencing stages at the reduced rate. Together these form a cascade of `STAGES` running sums of length `RATE`. The impulse response of that cascade is close to a B-spline of degree `STAGES-1`, so the passband falls off gently toward the edge.

A three-tap correction then works on consecutive decimated results. Its taps sit one output period apart, which is `RATE` input samples. It weights the newest result and the oldest result by -1/16 and the middle result by 9/8. This flattens the passband at the price of somewhat higher sidelobes. The gain of `RATE^STAGES` is then removed. When `RATE` is a power of two this is a plain arithmetic shift. Otherwise it is a multiply by a rounded reciprocal followed by a shift.

The block is a fixed building block for narrow low-pass paths, such as recovering a DC level from a heavily oversampled measurement. Samples enter as a valid/data pair. One valid/data pair leaves per decimation period, once the pipeline is full.

Top module: `cicp_decim`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first result is due, `out_vld` is 0 and `out_dat` is 0.
- R2: A sample is taken only on a rising clock edge with `in_vld` high. Cycles with `in_vld` low change neither the output stream nor its timing, other than stretching it.
- R3: Counting accepted samples from reset, the edge that accepts sample number `(j+1)*RATE` closes block j. For a block that is emitted, `out_vld` is high for exactly the one cycle that follows the second rising edge after that accepting edge.
- R4: Blocks 0 through `STAGES` (the first `STAGES+1` blocks after reset) produce no `out_vld`.
- R5: The cascade value c[j] is the input sequence convolved with `STAGES` boxcars of length `RATE` (all taps 1), read at input index `j*RATE+RATE-1`. Inputs before reset count as zero.
- R6: The corrected value, scaled by 16, is v[j] = 18*c[j-1] - c[j-2] - c[j]. Cascade values with a negative index count as zero.
- R7: When `RATE` is a power of two, `out_dat` is the low `OUT_W` bits of v[j] arithmetically shifted right by G+4, where G = `STAGES`*log2(`RATE`).
- R8: Otherwise, with G = `STAGES`*ceil(log2 `RATE`) and K = floor((2^(G+`FRAC`) + `RATE`^`STAGES`/2) / `RATE`^`STAGES`), `out_dat` is the low `OUT_W` bits of (v[j]*K) arithmetically shifted right by G+`FRAC`+4.
- R9: The integrator and differencing registers are `IN_W`+G bits wide and wrap in two's complement. Long runs of full-scale input of either sign still give the results of R5 to R8.
- R10: With `RATE` a power of two and a constant input x held long enough to fill the cascade, `out_dat` equals x exactly.
- R11: `out_vld` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input sample present |
| in_dat | input | IN_W | Input sample, signed two's complement |
| out_vld | output | 1 | One-cycle strobe marking a decimated result |
| out_dat | output | OUT_W | Decimated, corrected and normalised result, signed |

## Verification
The bench drives two instances from the same stimulus. One uses a rate of 5 with three stages, so it takes the multiply path. The other uses a rate of 4 with two stages, so it takes the shift path. A held constant proves the unit gain of the shift path and that the warm-up suppression ends on the right block. A single impulse shows the spline shape and each correction tap on its own. Pseudo-random data with random idle cycles separates true sample counting from cycle counting. Long full-scale runs of both signs force the accumulators to wrap, which separates correct modular arithmetic from a wrongly sized register.

// File: rtl/cicp_pkg.sv
package cicp_pkg;

   // integer power, evaluated at elaboration time
   function automatic longint ipow(input int base, input int expo);
      longint r;
      r = 1;
      for (int i = 0; i < expo; i++) r = r * base;
      return r;
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   // rounded reciprocal of rate^stages, scaled by 2^shift
   function automatic longint recip(input int rate, input int stages, input int shift);
      longint nm;
      nm = ipow(rate, stages);
      return ((longint'(1) <<< shift) + nm / 2) / nm;
   endfunction

endpackage

// File: rtl/cicp_integ.sv
module cicp_integ #(
   parameter int IN_W   = 16,
   parameter int STAGES = 3,
   parameter int RATE   = 5,
   parameter int ACC_W  = 25
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_vld,
   input  logic signed [IN_W-1:0]  in_dat,
   output logic                    dec_vld,
   output logic signed [ACC_W-1:0] dec_dat
);
   localparam int PH_W = (RATE > 1) ? $clog2(RATE) : 1;
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(RATE - 1);

   logic signed [ACC_W-1:0] acc_q [STAGES];
   logic signed [ACC_W-1:0] acc_d [STAGES];
   logic [PH_W-1:0]         phase_q;

   // all integrators settle in the same cycle the sample arrives
   for (genvar k = 0; k < STAGES; k++) begin : g_int
      if (k == 0) begin : g_head
         assign acc_d[k] = acc_q[k] + {{(ACC_W-IN_W){in_dat[IN_W-1]}}, in_dat};
      end else begin : g_tail
         assign acc_d[k] = acc_q[k] + acc_d[k-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      acc_q[k] <= '0;
         else if (in_vld) acc_q[k] <= acc_d[k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         dec_vld <= 1'b0;
         dec_dat <= '0;
      end else begin
         dec_vld <= 1'b0;
         if (in_vld) begin
            if (phase_q == PH_LAST) begin
               phase_q <= '0;
               dec_vld <= 1'b1;
               dec_dat <= acc_d[STAGES-1];
            end else begin
               phase_q <= phase_q + 1'b1;
            end
         end
      end
   end

   // R3
   dec_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld |=> !dec_vld);
   // R3
   phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q <= PH_LAST);
   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> $stable(phase_q));

endmodule

// File: rtl/cicp_comb.sv
module cicp_comb #(
   parameter int STAGES = 3,
   parameter int ACC_W  = 25
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    vld_i,
   input  logic signed [ACC_W-1:0] dat_i,
   output logic signed [ACC_W-1:0] c_dat
);
   logic signed [ACC_W-1:0] diff [STAGES+1];
   logic signed [ACC_W-1:0] dly_q [STAGES];

   assign diff[0] = dat_i;

   for (genvar k = 1; k <= STAGES; k++) begin : g_cmb
      assign diff[k] = diff[k-1] - dly_q[k-1];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     dly_q[k-1] <= '0;
         else if (vld_i) dly_q[k-1] <= diff[k-1];
      end
   end

   assign c_dat = diff[STAGES];

   // R2
   comb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_i |=> $stable(dly_q[0]));

endmodule

// File: rtl/cicp_corr.sv
module cicp_corr #(
   parameter int STAGES = 3,
   parameter int ACC_W  = 25,
   parameter int V_W    = 30
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  vld_i,
   input  logic signed [ACC_W-1:0] c_i,
   output logic                  v_vld,
   output logic signed [V_W-1:0] v_dat
);
   localparam int LIM   = STAGES + 1;
   localparam int CNT_W = $clog2(LIM + 1);
   localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(LIM);

   logic signed [ACC_W-1:0] z1_q, z2_q;
   logic signed [V_W-1:0]   cx, z1x, z2x, v_d;
   logic [CNT_W-1:0]        blk_cnt;

   assign cx  = V_W'(c_i);
   assign z1x = V_W'(z1_q);
   assign z2x = V_W'(z2_q);

   // 16 * (9/8) = 16 + 2 on the middle tap; outer taps are -1
   assign v_d = (z1x <<< 4) + (z1x <<< 1) - z2x - cx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         z1_q    <= '0;
         z2_q    <= '0;
         blk_cnt <= '0;
         v_vld   <= 1'b0;
         v_dat   <= '0;
      end else begin
         v_vld <= 1'b0;
         if (vld_i) begin
            z1_q  <= c_i;
            z2_q  <= z1_q;
            v_dat <= v_d;
            if (blk_cnt == CNT_LIM) v_vld <= 1'b1;
            else                    blk_cnt <= blk_cnt + 1'b1;
         end
      end
   end

   // R4
   warm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      v_vld |-> (blk_cnt == CNT_LIM));
   // R4
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blk_cnt <= CNT_LIM);

endmodule

// File: rtl/cicp_norm.sv
module cicp_norm
   import cicp_pkg::*;
#(
   parameter int STAGES = 3,
   parameter int RATE   = 5,
   parameter int V_W    = 30,
   parameter int OUT_W  = 17,
   parameter int FRAC   = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    vld_i,
   input  logic signed [V_W-1:0]   v_i,
   output logic                    out_vld,
   output logic signed [OUT_W-1:0] out_dat
);
   localparam bit P2   = is_pow2(RATE);
   localparam int GROW = STAGES * $clog2(RATE);

   logic signed [OUT_W-1:0] norm_d;

   if (P2) begin : g_shift
      localparam int SH = GROW + 4;
      assign norm_d = OUT_W'(v_i >>> SH);
   end else begin : g_mult
      localparam int     SH  = GROW + FRAC + 4;
      localparam longint KV  = recip(RATE, STAGES, GROW + FRAC);
      localparam int     K_W = FRAC + STAGES + 3;
      localparam int     P_W = V_W + K_W;
      logic signed [K_W-1:0] kc;
      logic signed [P_W-1:0] prod;
      assign kc     = K_W'(KV);
      assign prod   = P_W'(v_i) * P_W'(kc);
      assign norm_d = OUT_W'(prod >>> SH);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         out_dat <= '0;
      end else begin
         out_vld <= vld_i;
         if (vld_i) out_dat <= norm_d;
      end
   end

   // R3
   norm_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> $past(vld_i));
   // R1
   quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_i |=> $stable(out_dat));

endmodule

// File: rtl/cicp_decim.sv
module cicp_decim
   import cicp_pkg::*;
#(
   parameter int IN_W   = 16,
   parameter int STAGES = 3,
   parameter int RATE   = 5,
   parameter int FRAC   = 16,
   parameter int OUT_W  = IN_W + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_vld,
   input  logic signed [IN_W-1:0]  in_dat,
   output logic                    out_vld,
   output logic signed [OUT_W-1:0] out_dat
);
   localparam int GROW  = STAGES * $clog2(RATE);
   localparam int ACC_W = IN_W + GROW;
   localparam int V_W   = ACC_W + 5;

   initial begin
      rate_param_chk:   assert (RATE >= 2) else $error("RATE must be at least 2");
      stage_param_chk:  assert (STAGES >= 1 && STAGES <= 8) else $error("STAGES out of range");
      width_param_chk:  assert (OUT_W >= IN_W + 1 && OUT_W <= V_W) else $error("OUT_W out of range");
      frac_param_chk:   assert (FRAC >= 4 && GROW + FRAC < 48) else $error("FRAC out of range");
   end

   logic                    dec_vld;
   logic signed [ACC_W-1:0] dec_dat;
   logic signed [ACC_W-1:0] c_dat;
   logic                    v_vld;
   logic signed [V_W-1:0]   v_dat;

   cicp_integ #(.IN_W(IN_W), .STAGES(STAGES), .RATE(RATE), .ACC_W(ACC_W)) u_integ (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_dat(in_dat),
      .dec_vld(dec_vld), .dec_dat(dec_dat));

   cicp_comb #(.STAGES(STAGES), .ACC_W(ACC_W)) u_comb (
      .clk(clk), .rst_n(rst_n), .vld_i(dec_vld), .dat_i(dec_dat), .c_dat(c_dat));

   cicp_corr #(.STAGES(STAGES), .ACC_W(ACC_W), .V_W(V_W)) u_corr (
      .clk(clk), .rst_n(rst_n), .vld_i(dec_vld), .c_i(c_dat),
      .v_vld(v_vld), .v_dat(v_dat));

   cicp_norm #(.STAGES(STAGES), .RATE(RATE), .V_W(V_W), .OUT_W(OUT_W), .FRAC(FRAC)) u_norm (
      .clk(clk), .rst_n(rst_n), .vld_i(v_vld), .v_i(v_dat),
      .out_vld(out_vld), .out_dat(out_dat));

   // R11
   out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |=> !out_vld);
   // R3
   out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> $past(dec_vld, 2));

endmodule

// File: tb/cicp_decim_tb.sv
module cicp_decim_tb;
   localparam int IN_W = 16;
   localparam int OW   = IN_W + 1;
   localparam int NA = 5, MA = 3;   // multiply path
   localparam int NB = 4, MB = 2;   // shift path
   localparam int FR = 16;

   typedef struct { int cyc; longint val; } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_vld = 1'b0;
   logic signed [IN_W-1:0] in_dat = '0;
   logic out_vld_a, out_vld_b;
   logic signed [OW-1:0] out_dat_a, out_dat_b;

   int errors = 0, checks = 0, pc = 0;
   bit done = 0;
   longint xs[$];
   exp_t qa[$], qb[$];
   logic signed [OW-1:0] last_b = '0;

   always #5 clk = ~clk;

   cicp_decim #(.IN_W(IN_W), .STAGES(MA), .RATE(NA), .FRAC(FR)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_dat(in_dat),
      .out_vld(out_vld_a), .out_dat(out_dat_a));

   cicp_decim #(.IN_W(IN_W), .STAGES(MB), .RATE(NB), .FRAC(FR)) u_dut2 (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_dat(in_dat),
      .out_vld(out_vld_b), .out_dat(out_dat_b));

   // R5: boxcar-cascade value for block j
   function automatic longint cic_ref(int n, int m, int j);
      longint h[64], t[64], s;
      int len;
      if (j < 0) return 0;
      foreach (h[i]) h[i] = 0;
      h[0] = 1; len = 1;
      for (int st = 0; st < m; st++) begin
         for (int i = 0; i < len + n - 1; i++) begin
            t[i] = 0;
            for (int d = 0; d < n; d++)
               if (i - d >= 0 && i - d < len) t[i] += h[i - d];
         end
         len = len + n - 1;
         for (int i = 0; i < len; i++) h[i] = t[i];
      end
      s = 0;
      for (int k = 0; k < len; k++) begin
         int a = j * n + n - 1 - k;
         if (a >= 0 && a < xs.size()) s += h[k] * xs[a];
      end
      return s;
   endfunction

   // R6, R7, R8
   function automatic longint out_ref(int n, int m, int j);
      longint v, nm, k;
      int g;
      v = 18 * cic_ref(n, m, j - 1) - cic_ref(n, m, j - 2) - cic_ref(n, m, j);
      g = m * $clog2(n);
      if ((n & (n - 1)) == 0) return v >>> (g + 4);
      nm = 1;
      for (int i = 0; i < m; i++) nm *= n;
      k = ((longint'(1) <<< (g + FR)) + nm / 2) / nm;
      return (v * k) >>> (g + FR + 4);
   endfunction

   // reference model: record accepted samples, schedule results (R2, R3, R4)
   always @(posedge clk) begin
      pc <= pc + 1;
      if (rst_n && in_vld) begin
         int j;
         exp_t e;
         xs.push_back(longint'(in_dat));
         if (xs.size() % NA == 0) begin
            j = xs.size() / NA - 1;
            if (j >= MA + 1) begin e.cyc = pc + 1 + 2; e.val = out_ref(NA, MA, j); qa.push_back(e); end
         end
         if (xs.size() % NB == 0) begin
            j = xs.size() / NB - 1;
            if (j >= MB + 1) begin e.cyc = pc + 1 + 2; e.val = out_ref(NB, MB, j); qb.push_back(e); end
         end
      end
   end

   logic prev_a = 1'b0, prev_b = 1'b0;

   // every-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         bit ea, eb;
         logic [OW-1:0] xa, xb;
         ea = (qa.size() > 0) && (qa[0].cyc == pc);
         eb = (qb.size() > 0) && (qb[0].cyc == pc);
         checks += 2;
         if (out_vld_a !== ea) begin errors++; $display("FAIL R3 R4 valid A: got %0b exp %0b at %0d", out_vld_a, ea, pc); end
         if (out_vld_b !== eb) begin errors++; $display("FAIL R3 R4 valid B: got %0b exp %0b at %0d", out_vld_b, eb, pc); end
         if (ea) begin
            xa = OW'(qa[0].val); checks++;
            if (out_dat_a !== xa) begin errors++; $display("FAIL R5 R6 R8 data A: got %0d exp %0d", out_dat_a, $signed(xa)); end
            void'(qa.pop_front());
         end
         if (eb) begin
            xb = OW'(qb[0].val); checks++;
            if (out_dat_b !== xb) begin errors++; $display("FAIL R5 R6 R7 data B: got %0d exp %0d", out_dat_b, $signed(xb)); end
            void'(qb.pop_front());
         end
         if (out_vld_b) last_b = out_dat_b;
         // R11
         checks++;
         if ((prev_a && out_vld_a) || (prev_b && out_vld_b)) begin
            errors++; $display("FAIL R11 back-to-back valid: got 1 exp 0 at %0d", pc);
         end
         prev_a = out_vld_a; prev_b = out_vld_b;
      end
   end

   task automatic send(input logic signed [IN_W-1:0] d, input bit v);
      @(negedge clk);
      in_vld = v;
      in_dat = d;
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: got timeout exp completion");
         summary();
         $finish;
      end
   end

   initial begin
      int lfsr;
      lfsr = 32'h1ACE5;
      // R1: reset state
      repeat (3) @(negedge clk);
      checks += 2;
      if (out_vld_a !== 1'b0 || out_dat_a !== '0) begin errors++; $display("FAIL R1 reset A: got %0b/%0d exp 0/0", out_vld_a, out_dat_a); end
      if (out_vld_b !== 1'b0 || out_dat_b !== '0) begin errors++; $display("FAIL R1 reset B: got %0b/%0d exp 0/0", out_vld_b, out_dat_b); end
      @(negedge clk) rst_n = 1'b1;
      // R1: quiet during warm-up
      for (int i = 0; i < 12; i++) send(16'sd700, 1'b1);
      checks++;
      if (out_vld_a !== 1'b0 || out_dat_a !== '0) begin errors++; $display("FAIL R1 warm-up A: got %0b/%0d exp 0/0", out_vld_a, out_dat_a); end
      // R10: constant input on the shift path
      for (int i = 0; i < 120; i++) send(16'sd1000, 1'b1);
      for (int i = 0; i < 4; i++) send(16'sd0, 1'b0);
      checks++;
      if (last_b !== 17'sd1000) begin errors++; $display("FAIL R10 DC gain B: got %0d exp 1000", last_b); end
      // R5 R6: impulse then zeros
      send(16'sd20000, 1'b1);
      for (int i = 0; i < 80; i++) send(16'sd0, 1'b1);
      // R2: random data with random idle cycles
      for (int i = 0; i < 3000; i++) begin
         lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h80200003 : 0);
         send(IN_W'(lfsr), lfsr[20] | lfsr[9]);
      end
      // R9: long full-scale runs force wraparound
      for (int i = 0; i < 400; i++) send(-16'sd32768, 1'b1);
      for (int i = 0; i < 400; i++) send(16'sd32767, 1'b1);
      for (int i = 0; i < 300; i++) send((i % 2) ? 16'sd32767 : -16'sd32768, 1'b1);
      for (int i = 0; i < 10; i++) send(16'sd0, 1'b0);
      // every scheduled result must have appeared
      checks++;
      if (qa.size() != 0 || qb.size() != 0) begin errors++; $display("FAIL R3 pending results: got %0d exp 0", qa.size() + qb.size()); end
      done = 1;
      summary();
      $finish;
   end
endmodule